// File: doc/BRIEF.md
# Configurable Lane Serializer/Deserializer

This block is a single 40-bit shift register that can be turned into a parallel-to-serial converter (multiplexer direction) or a serial-to-parallel converter (demultiplexer direction). A 3-bit layout select divides the register into a number of serial lanes, each with a fixed depth. In the multiplexer direction a 40-bit parallel word is taken in and shifted out on up to eight serial lanes. In the demultiplexer direction up to eight serial lanes are shifted in and presented as a 40-bit parallel word.

The block stays idle after reset until a start edge arrives on the sync input. At that edge it captures the direction, the layout and the timing source. With internal timing it then waits for a warm-up period and after that exchanges one parallel word every n cycles, where n is the depth of one lane. With external timing the sync input and a shift-enable input act directly as load and shift strobes. The parallel input uses valid/ready. Ready marks the single cycle in which a word is taken. The serial line cannot stall, so back-pressure does not exist: a missing word is replaced by zeros, and the parallel output raises valid for one cycle with no ready.

Top module: `sdr_lane_serdes`

## Requirements
- R1: The select code (lanes x depth) gives 0: 8x5, 1: 8x4, 2: 5x8, 3: 4x10, 4: 2x16, 5: 2x20, 6: 1x32, 7: 1x40.
- R2: A direction input of 0 selects the multiplexer direction and 1 selects the demultiplexer direction. In the demultiplexer direction with internal timing, the serial outputs stay 0 and parallel ready stays low. In the multiplexer direction, parallel valid stays low.
- R3: Lane k carries parallel bits k*n to k*n+n-1, least significant bit first.
- R4: After reset the block is idle (all outputs 0) until the sync input is sampled low and then high. Holding sync high from reset does not start the block.
- R5: With internal timing, the first parallel transfer happens at the clock edge 2n cycles after the start edge, and a further transfer follows every n cycles. Ready, or the output valid pulse, is high for one cycle per transfer.
- R6: In the multiplexer direction, bit j of a word taken at edge L appears on the serial outputs after edge L+2+j.
- R7: Serial lanes beyond the selected lane count, and parallel output bits at or above lanes*n, are driven to 0.
- R8: With external timing (timing input 1), the following apply after the start edge. Sync low with shift-enable low loads the parallel word and shows ready. Sync high with shift-enable low shifts one serial bit into each lane and updates the parallel output with a valid pulse. Shift-enable high shifts each lane one bit toward its serial output, which follows one edge later.
- R9: Changes to the direction, select or timing inputs have no effect until the next start edge.
- R10: With internal timing in the multiplexer direction, if valid is low in the ready cycle, an all-zero word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Direction: 0 serialize, 1 deserialize |
| cfg_sel_i | input | 3 | Lane/depth layout code |
| ext_timing_i | input | 1 | 1 selects external strobe timing |
| sync_i | input | 1 | Start edge; load/entry strobe in external timing |
| shift_en_i | input | 1 | External shift enable |
| par_data_i | input | 40 | Parallel word to serialize |
| par_valid_i | input | 1 | Parallel input word present |
| par_ready_o | output | 1 | Parallel word taken this cycle |
| ser_i | input | 8 | Serial input lanes |
| ser_o | output | 8 | Serial output lanes |
| par_data_o | output | 40 | Assembled parallel word |
| par_valid_o | output | 1 | One-cycle pulse for a new parallel word |

## Verification
The bench uses the default build: a 40-bit word and eight lanes. With these values every one of the eight layouts can be reached, with depths from 4 to 40, which gives warm-up periods of up to 80 cycles. Each layout is run in both directions with random words and random lane data. During every run the direction, select and timing inputs are scrambled after the start edge, and one skipped word is sent in each multiplexer run. External strobe timing is exercised on the 5x8 layout through serial entry, shifting and parallel loading.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int WORD_W     = 40;
  localparam int LANES      = 8;
  localparam int SEL_W      = 3;
  localparam int DEPTH_W    = $clog2(WORD_W + 1);
  localparam int LANE_CNT_W = $clog2(LANES + 1);

  typedef struct packed {
    logic             demux;
    logic             ext;
    logic [SEL_W-1:0] sel;
  } sdr_cfg_t;

  // per-lane depth n of each layout code
  function automatic logic [DEPTH_W-1:0] depth_of(input logic [SEL_W-1:0] s);
    case (s)
      3'd0:    depth_of = DEPTH_W'(5);
      3'd1:    depth_of = DEPTH_W'(4);
      3'd2:    depth_of = DEPTH_W'(8);
      3'd3:    depth_of = DEPTH_W'(10);
      3'd4:    depth_of = DEPTH_W'(16);
      3'd5:    depth_of = DEPTH_W'(20);
      3'd6:    depth_of = DEPTH_W'(32);
      default: depth_of = DEPTH_W'(40);
    endcase
  endfunction

  // active lane count of each layout code
  function automatic logic [LANE_CNT_W-1:0] lanes_of(input logic [SEL_W-1:0] s);
    case (s)
      3'd0, 3'd1: lanes_of = LANE_CNT_W'(8);
      3'd2:       lanes_of = LANE_CNT_W'(5);
      3'd3:       lanes_of = LANE_CNT_W'(4);
      3'd4, 3'd5: lanes_of = LANE_CNT_W'(2);
      default:    lanes_of = LANE_CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/sdr_start_timer.sv
module sdr_start_timer
  import sdr_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int CNT_W = $clog2(2 * W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             mode_i,
  input  logic             ext_i,
  input  logic [SEL_W-1:0] sel_i,
  output sdr_cfg_t         cfg_o,
  output logic             started_o,
  output logic             start_o,
  output logic             latch_o
);
  logic             sync_q;
  logic             warm_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] n_ext;
  logic [CNT_W-1:0] limit;

  assign n_ext   = CNT_W'(depth_of(cfg_o.sel));
  assign limit   = warm_q ? ((n_ext << 1) - CNT_W'(1)) : (n_ext - CNT_W'(1));
  assign start_o = sync_i & ~sync_q;
  assign latch_o = started_o & ~cfg_o.ext & ~start_o & (cnt_q == limit);

  // sync_q resets high: a start edge needs a sampled low first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 1'b1;
      cfg_o     <= '0;
      started_o <= 1'b0;
      warm_q    <= 1'b1;
      cnt_q     <= '0;
    end else begin
      sync_q <= sync_i;
      if (start_o) begin
        cfg_o     <= '{demux: mode_i, ext: ext_i, sel: sel_i};
        started_o <= 1'b1;
        warm_q    <= 1'b1;
        cnt_q     <= '0;
      end else if (started_o && !cfg_o.ext) begin
        if (latch_o) begin
          cnt_q  <= '0;
          warm_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdr_shift_core.sv
module sdr_shift_core
  import sdr_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NL = LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sdr_cfg_t      cfg_i,
  input  logic          started_i,
  input  logic          start_i,
  input  logic          latch_i,
  input  logic          sync_i,
  input  logic          shift_en_i,
  input  logic [W-1:0]  par_data_i,
  input  logic          par_valid_i,
  output logic          par_ready_o,
  input  logic [NL-1:0] ser_i,
  output logic [NL-1:0] ser_o,
  output logic [W-1:0]  par_data_o,
  output logic          par_valid_o
);
  localparam int IDX_W = $clog2(W);

  logic [DEPTH_W-1:0]    n;
  logic [LANE_CNT_W-1:0] nl;
  logic [W-1:0]          sr_q, hold_q, entry_v, used_mask, par_q;
  logic [NL-1:0]         pick_v, ser_q;
  logic                  load_d_q, par_vld_q;
  logic                  mux_run, dmx_run, ext_act, ext_load, ext_entry, ext_shift, par_take;

  assign n  = depth_of(cfg_i.sel);
  assign nl = lanes_of(cfg_i.sel);

  assign mux_run   = started_i & ~cfg_i.ext & ~cfg_i.demux & ~start_i;
  assign dmx_run   = started_i & ~cfg_i.ext &  cfg_i.demux & ~start_i;
  assign ext_act   = started_i &  cfg_i.ext & ~start_i;
  assign ext_load  = ext_act & ~sync_i & ~shift_en_i;
  assign ext_entry = ext_act &  sync_i & ~shift_en_i;
  assign ext_shift = ext_act &  shift_en_i;
  assign par_take  = (dmx_run & latch_i) | ext_entry;

  assign par_ready_o = (mux_run & latch_i) | ext_load;

  // every lane shifts right; each lane's top slot takes its serial bit
  always_comb begin
    entry_v = sr_q >> 1;
    for (int k = 0; k < NL; k++) begin
      if (k < int'(nl)) entry_v[IDX_W'(k * int'(n) + int'(n) - 1)] = ser_i[k];
    end
  end

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign pick_v[k] = (k < int'(nl)) ? sr_q[IDX_W'(k * int'(n))] : 1'b0;
  end

  for (genvar p = 0; p < W; p++) begin : g_bit
    assign used_mask[p] = (p < int'(nl) * int'(n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q      <= '0;
      hold_q    <= '0;
      ser_q     <= '0;
      par_q     <= '0;
      load_d_q  <= 1'b0;
      par_vld_q <= 1'b0;
    end else if (start_i) begin
      sr_q      <= '0;
      ser_q     <= '0;
      par_q     <= '0;
      load_d_q  <= 1'b0;
      par_vld_q <= 1'b0;
    end else begin
      load_d_q <= mux_run & latch_i;
      if (mux_run && latch_i) hold_q <= par_valid_i ? par_data_i : '0;

      if (mux_run)                      sr_q <= load_d_q ? hold_q : (sr_q >> 1);
      else if (dmx_run)                 sr_q <= entry_v;
      else if (ext_load && par_valid_i) sr_q <= par_data_i;
      else if (ext_entry)               sr_q <= entry_v;
      else if (ext_shift)               sr_q <= sr_q >> 1;

      ser_q     <= (mux_run | ext_act) ? pick_v : '0;
      par_vld_q <= par_take;
      if (par_take) par_q <= entry_v & used_mask;
    end
  end

  assign ser_o       = ser_q;
  assign par_data_o  = par_q;
  assign par_valid_o = par_vld_q;
endmodule

// File: rtl/sdr_lane_serdes.sv
module sdr_lane_serdes
  import sdr_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NL = LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic             ext_timing_i,
  input  logic             sync_i,
  input  logic             shift_en_i,
  input  logic [W-1:0]     par_data_i,
  input  logic             par_valid_i,
  output logic             par_ready_o,
  input  logic [NL-1:0]    ser_i,
  output logic [NL-1:0]    ser_o,
  output logic [W-1:0]     par_data_o,
  output logic             par_valid_o
);
  sdr_cfg_t act_cfg;
  logic     started, start_pulse, latch_pulse;

  sdr_start_timer #(.W(W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_i   (sync_i),
    .mode_i   (mode_i),
    .ext_i    (ext_timing_i),
    .sel_i    (cfg_sel_i),
    .cfg_o    (act_cfg),
    .started_o(started),
    .start_o  (start_pulse),
    .latch_o  (latch_pulse)
  );

  sdr_shift_core #(.W(W), .NL(NL)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_i      (act_cfg),
    .started_i  (started),
    .start_i    (start_pulse),
    .latch_i    (latch_pulse),
    .sync_i     (sync_i),
    .shift_en_i (shift_en_i),
    .par_data_i (par_data_i),
    .par_valid_i(par_valid_i),
    .par_ready_o(par_ready_o),
    .ser_i      (ser_i),
    .ser_o      (ser_o),
    .par_data_o (par_data_o),
    .par_valid_o(par_valid_o)
  );
endmodule

// File: rtl/sdr_lane_serdes_chk.sv
module sdr_lane_serdes_chk
  import sdr_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NL = LANES
) (
  input logic          clk,
  input logic          rst_n,
  input sdr_cfg_t      cfg,
  input logic          started,
  input logic          start,
  input logic [W-1:0]  par_data_i,
  input logic          par_valid_i,
  input logic          par_ready_o,
  input logic [NL-1:0] ser_o,
  input logic [W-1:0]  par_data_o,
  input logic          par_valid_o
);
  logic [NL-1:0] lane_ok;
  logic [W-1:0]  bit_ok;

  always_comb begin
    for (int k = 0; k < NL; k++) lane_ok[k] = (k < int'(lanes_of(cfg.sel)));
    for (int p = 0; p < W; p++)
      bit_ok[p] = (p < int'(lanes_of(cfg.sel)) * int'(depth_of(cfg.sel)));
  end

  p_idle_before_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (ser_o == '0 && par_data_o == '0 && !par_valid_o && !par_ready_o));

  p_unused_lanes_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_o & ~lane_ok) == '0);

  p_unused_bits_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (par_data_o & ~bit_ok) == '0);

  p_cfg_only_at_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cfg));

  p_ready_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_ready_o && !cfg.ext) |=> !par_ready_o);

  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (par_valid_o && !cfg.ext) |=> !par_valid_o);

  p_demux_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (started && cfg.demux && !cfg.ext) |-> (ser_o == '0 && !par_ready_o));

  p_mux_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (par_ready_o && par_valid_i && !cfg.ext && !cfg.demux) ##1 !start ##1 !start
      |=> (ser_o[0] == $past(par_data_i[0], 3)));
endmodule

bind sdr_lane_serdes sdr_lane_serdes_chk #(.W(W), .NL(NL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg        (act_cfg),
  .started    (started),
  .start      (start_pulse),
  .par_data_i (par_data_i),
  .par_valid_i(par_valid_i),
  .par_ready_o(par_ready_o),
  .ser_o      (ser_o),
  .par_data_o (par_data_o),
  .par_valid_o(par_valid_o)
);

// File: tb/sdr_lane_serdes_tb.sv
module sdr_lane_serdes_tb;
  logic        clk = 1'b0;
  logic        rst_n, mode_i, ext_timing_i, sync_i, shift_en_i, par_valid_i;
  logic [2:0]  cfg_sel_i;
  logic [39:0] par_data_i, par_data_o;
  logic [7:0]  ser_i, ser_o;
  logic        par_ready_o, par_valid_o;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  sdr_lane_serdes u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cfg_sel_i(cfg_sel_i),
    .ext_timing_i(ext_timing_i), .sync_i(sync_i), .shift_en_i(shift_en_i),
    .par_data_i(par_data_i), .par_valid_i(par_valid_i), .par_ready_o(par_ready_o),
    .ser_i(ser_i), .ser_o(ser_o), .par_data_o(par_data_o), .par_valid_o(par_valid_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // layout table from R1
  function automatic int depth_f(input int s);
    case (s)
      0: return 5;  1: return 4;  2: return 8;  3: return 10;
      4: return 16; 5: return 20; 6: return 32; default: return 40;
    endcase
  endfunction

  function automatic int lanes_f(input int s);
    case (s)
      0, 1: return 8;  2: return 5;  3: return 4;
      4, 5: return 2;  default: return 1;
    endcase
  endfunction

  // serial lane values for bit j of word w (R3, R7)
  function automatic logic [7:0] lane_bits(input logic [39:0] w, input int s, input int j);
    logic [7:0] r = '0;
    for (int k = 0; k < lanes_f(s); k++) r[k] = w[k * depth_f(s) + j];
    return r;
  endfunction

  task automatic scramble_cfg();
    mode_i       = 1'($urandom);
    cfg_sel_i    = 3'($urandom);
    ext_timing_i = 1'($urandom);
  endtask

  task automatic do_start(input bit m, input int s, input bit e);
    @(negedge clk);
    sync_i = 1'b0; mode_i = m; cfg_sel_i = 3'(s); ext_timing_i = e; shift_en_i = 1'b0;
    @(negedge clk);
    sync_i = 1'b1;
  endtask

  task automatic run_mux(input int s);
    int          n = depth_f(s);
    logic [39:0] eff [0:7];
    logic [7:0]  exp_ser;
    do_start(1'b0, s, 1'b0);
    for (int i = 1; i <= 6 * n + 3; i++) begin
      int  rel = i - 2 * n;
      bit  rdy = (rel >= 0) && (rel % n == 0);
      @(negedge clk);
      scramble_cfg();
      ser_i = 8'($urandom);
      chk(par_ready_o == rdy, "R5 mux ready timing", 64'(par_ready_o), 64'(rdy));
      if (rdy) begin
        logic [39:0] w = {8'($urandom), 32'($urandom)};
        par_data_i  = w;
        par_valid_i = (rel / n != 1);
        eff[rel / n] = par_valid_i ? w : '0;  // R10 skipped word
      end
      if (i >= 2 * n + 3) exp_ser = lane_bits(eff[(i - 3 - 2 * n) / n], s, (i - 3 - 2 * n) % n);
      else                exp_ser = '0;
      chk(ser_o == exp_ser, "R6 R3 R1 mux serial lanes", 64'(ser_o), 64'(exp_ser));
      chk(par_valid_o == 1'b0, "R2 mux no parallel valid", 64'(par_valid_o), 64'(0));
    end
  endtask

  task automatic run_demux(input int s);
    int          n = depth_f(s);
    logic [7:0]  hist [0:511];
    logic [39:0] exp_w;
    do_start(1'b1, s, 1'b0);
    for (int i = 1; i <= 5 * n + 1; i++) begin
      bit v = (i - 1 >= 2 * n) && ((i - 1 - 2 * n) % n == 0);
      @(negedge clk);
      scramble_cfg();
      chk(par_valid_o == v, "R5 demux valid timing", 64'(par_valid_o), 64'(v));
      if (v) begin
        exp_w = '0;
        for (int k = 0; k < lanes_f(s); k++)
          for (int j = 0; j < n; j++) exp_w[k * n + j] = hist[i - n + j][k];
        chk(par_data_o == exp_w, "R3 R7 demux word", 64'(par_data_o), 64'(exp_w));
      end
      chk(ser_o == '0 && !par_ready_o, "R2 demux quiet", 64'({par_ready_o, ser_o}), 64'(0));
      hist[i] = 8'($urandom);
      ser_i   = hist[i];
    end
  endtask

  task automatic run_ext();
    logic [7:0]  hist [0:7];
    logic [39:0] w, w2;
    do_start(1'b0, 2, 1'b1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      scramble_cfg();
      if (i == 0) chk(par_valid_o == 1'b0, "R8 no entry on start edge", 64'(par_valid_o), 64'(0));
      hist[i] = 8'($urandom);
      ser_i   = hist[i];
    end
    @(negedge clk);
    w = '0;
    for (int k = 0; k < 5; k++) for (int j = 0; j < 8; j++) w[k * 8 + j] = hist[j][k];
    chk(par_valid_o == 1'b1, "R8 entry valid", 64'(par_valid_o), 64'(1));
    chk(par_data_o == w, "R8 serial entry word", 64'(par_data_o), 64'(w));
    shift_en_i = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      chk(ser_o == lane_bits(w, 2, j), "R8 ext shift out", 64'(ser_o), 64'(lane_bits(w, 2, j)));
    end
    shift_en_i = 1'b0; sync_i = 1'b0;
    w2 = {8'($urandom), 32'($urandom)};
    par_data_i = w2; par_valid_i = 1'b1;
    #1 chk(par_ready_o == 1'b1, "R8 ext load ready", 64'(par_ready_o), 64'(1));
    @(negedge clk);
    shift_en_i = 1'b1; par_valid_i = 1'b0;
    #1 chk(par_ready_o == 1'b0, "R8 no ready while shifting", 64'(par_ready_o), 64'(0));
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      chk(ser_o == lane_bits(w2, 2, j), "R8 ext loaded shift", 64'(ser_o), 64'(lane_bits(w2, 2, j)));
    end
    shift_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    rst_n = 1'b0; sync_i = 1'b1; mode_i = 1'b0; cfg_sel_i = '0; ext_timing_i = 1'b0;
    shift_en_i = 1'b0; par_data_i = '0; par_valid_i = 1'b0; ser_i = '0;
    repeat (3) @(negedge clk);
    chk({ser_o, par_data_o, par_valid_o, par_ready_o} == '0, "R4 reset state",
        64'(ser_o), 64'(0));
    rst_n = 1'b1;
    // sync held high from reset: no start (R4)
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      scramble_cfg();
      par_valid_i = 1'b1; ser_i = 8'($urandom); shift_en_i = 1'($urandom);
      chk(ser_o == '0 && !par_ready_o && !par_valid_o, "R4 idle without edge",
          64'({par_valid_o, par_ready_o, ser_o}), 64'(0));
    end
    shift_en_i = 1'b0; par_valid_i = 1'b0;
    run_ext();
    for (int s = 0; s < 8; s++) begin
      run_mux(s);
      run_demux(s);
    end
    for (int r = 0; r < 6; r++) begin
      if (r[0]) run_demux(int'($urandom % 8));
      else      run_mux(int'($urandom % 8));
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule